// File: doc/BRIEF.md
# Selectable Watchdog Supervisor Reset

This block watches a host processor and pulls a shared reset line low when the host stops servicing it. A slow enable tick (nominally 4096 per second) drives an elapsed-time counter. A 2-bit select chooses one of three timeouts: a quarter second, three quarters of a second, or one and three quarters of a second. The fourth code turns the watchdog off. The host restarts the count by pulsing a kick strobe. When the count runs out, the block holds reset low for a fixed quarter second and then releases it.

A low-voltage flag from an external comparator drives the same reset line. Reset stays low for as long as the flag is active and for a further quarter second after the flag clears. The output is active low and is meant to drive an open-drain pad: low means pull down, high means let go. While reset is held, the watchdog count stays at zero. Counting starts again from zero when reset is released.

Top module: `wdt_supervisor`

## Requirements
- R1: After a synchronous reset through `rst_n`, `rst_out_n` is 1 (line released).
- R2: With select code 00, the line goes low right after the 7·(TICK_HZ/4)-th tick since the last restart, and not before.
- R3: With select code 01, the line goes low right after the 3·(TICK_HZ/4)-th tick since the last restart, and not before.
- R4: With select code 10, the line goes low right after the (TICK_HZ/4)-th tick since the last restart, and not before.
- R5: With select code 11, the watchdog never pulls the line low, however many ticks pass.
- R6: A one-cycle `kick` pulse clears the elapsed count, so a full new timeout is needed before the line goes low.
- R7: Any change of `wd_sel` clears the elapsed count. The new timeout is then measured from the change.
- R8: A watchdog reset holds the line low for exactly TICK_HZ/4 ticks and then releases it. Kicks during that hold have no effect. The timeout count starts again from zero at release.
- R9: The line is low from the clock after `lv_flag` is seen high. It stays low while the flag is high and is released TICK_HZ/4 ticks after the flag goes low.
- R10: `rst_out_n` is active low. The value 0 means the pad pulls down and 1 means the pad floats.
- R11: The count advances only in cycles where `tick_en` is 1. Any number of cycles without a tick leave the line high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| tick_en | input | 1 | Timebase enable, one cycle per tick (nominally 4096 Hz) |
| kick | input | 1 | Service strobe from the host; restarts the count |
| wd_sel | input | 2 | Timeout select: 00 long, 01 middle, 10 short, 11 off |
| lv_flag | input | 1 | Low-supply indication, active high |
| rst_out_n | output | 1 | Active-low reset; 0 drives the open-drain pad low |

## Verification
Each of the three timeout codes is run to expiry with no service. The bench checks that the line is still high one tick before the limit and low right after it, which separates the three limits from each other and from off-by-one faults. Other runs cover a kick part way through a count, a select change part way through a count, and a long idle stretch without ticks. These show whether restarts and tick gating act on the counter or are ignored. The off code is run for many ticks, kicks are sent while reset is held, and a low-voltage pulse of several ticks is applied. These runs separate the watchdog release path from the supply release path and confirm that counting resumes from zero after release.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        WD_LONG  = 2'b00,
        WD_MID   = 2'b01,
        WD_SHORT = 2'b10,
        WD_OFF   = 2'b11
    } wd_sel_e;

    // Timeout in ticks for a select code; qtr is the tick count of 250 ms.
    function automatic int unsigned wdt_limit(wd_sel_e s, int unsigned qtr);
        case (s)
            WD_LONG:  return 7 * qtr;
            WD_MID:   return 3 * qtr;
            WD_SHORT: return qtr;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/wdt_timer.sv
module wdt_timer #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          restart,
    input  logic [CW-1:0] limit,
    output logic          expire
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        expire = 1'b0;
        if (restart) begin
            tmr_d.cnt = '0;
        end else if (tick_en) begin
            if (tmr_q.cnt >= limit - CW'(1)) begin
                expire    = 1'b1;
                tmr_d.cnt = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R6/R7: a restart leaves the count at zero on the next cycle
    p_restart_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (tmr_q.cnt == '0));

endmodule

// File: rtl/wdt_hold.sv
module wdt_hold #(
    parameter int HW   = 11,
    parameter int HOLD = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic lv_flag,
    input  logic trip,
    output logic holding
);

    typedef struct packed {
        logic [HW-1:0] left;
    } hold_st_t;

    hold_st_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (lv_flag || trip) begin
            hold_d.left = HW'(HOLD);
        end else if (tick_en && hold_q.left != '0) begin
            hold_d.left = hold_q.left - HW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign holding = (hold_q.left != '0);

    // R8: an expiry arms the full release delay
    p_trip_arms_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (hold_q.left == HW'(HOLD)));

endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor #(
    parameter int TICK_HZ = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       kick,
    input  logic [1:0] wd_sel,
    input  logic       lv_flag,
    output logic       rst_out_n
);
    import wdt_pkg::*;

    localparam int QTR = TICK_HZ / 4;
    localparam int CW  = $clog2(7 * QTR + 1);
    localparam int HW  = $clog2(QTR + 1);

    typedef struct packed {
        wd_sel_e sel;
    } top_st_t;

    top_st_t top_d, top_q;
    wd_sel_e sel_now;
    logic    restart;
    logic    expire;
    logic    holding;
    logic [CW-1:0] limit;

    always_comb begin
        sel_now   = wd_sel_e'(wd_sel);
        top_d     = top_q;
        top_d.sel = sel_now;
        limit     = CW'(wdt_limit(sel_now, QTR));
        restart   = kick || (sel_now != top_q.sel) || (sel_now == WD_OFF) || holding;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '{sel: WD_LONG};
        else        top_q <= top_d;
    end

    wdt_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .restart (restart),
        .limit   (limit),
        .expire  (expire)
    );

    wdt_hold #(.HW(HW), .HOLD(QTR)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .lv_flag (lv_flag),
        .trip    (expire),
        .holding (holding)
    );

    assign rst_out_n = !holding;

    p_expire_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> tick_en);

    p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_sel == 2'b11) |-> !expire);

    p_expire_pulls_r2: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !rst_out_n);

    p_lv_pulls_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lv_flag |=> !rst_out_n);

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> $past(!lv_flag && tick_en));

endmodule

// File: tb/tb_wdt_supervisor.sv
module tb_wdt_supervisor;

    localparam int TICK_HZ = 16;
    localparam int Q = TICK_HZ / 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic kick = 1'b0;
    logic [1:0] wd_sel = 2'b00;
    logic lv_flag = 1'b0;
    logic rst_out_n;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_sel = 0;
    int m_cnt = 0;
    int m_hold = 0;
    logic m_out = 1'b1;

    always #10 clk = ~clk;

    wdt_supervisor #(.TICK_HZ(TICK_HZ)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .kick(kick),
        .wd_sel(wd_sel), .lv_flag(lv_flag), .rst_out_n(rst_out_n)
    );

    function automatic int lim_of(int s);
        if (s == 0) return 7 * Q;
        if (s == 1) return 3 * Q;
        if (s == 2) return Q;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 0; m_cnt = 0; m_hold = 0;
        end else begin
            bit fired;
            fired = 1'b0;
            if (kick || int'(wd_sel) != m_sel || wd_sel == 2'b11 || m_hold > 0)
                m_cnt = 0;
            else if (tick_en) begin
                m_cnt++;
                if (m_cnt >= lim_of(int'(wd_sel))) begin
                    fired = 1'b1;
                    m_cnt = 0;
                end
            end
            if (lv_flag || fired) m_hold = Q;
            else if (tick_en && m_hold > 0) m_hold--;
            m_sel = int'(wd_sel);
        end
        m_out = (m_hold == 0);
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_run++;
            if (rst_out_n !== m_out) begin
                n_fail++;
                $display("FAIL %s cycle compare: rst_out_n=%b expected=%b", cur_req, rst_out_n, m_out);
            end
        end
    end

    task automatic check(string req, logic act, logic expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: rst_out_n=%b expected=%b", req, act, expv);
        end
    endtask

    task automatic step(logic t);
        tick_en = t;
        @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            step(1'b0); step(1'b0); step(1'b0); step(1'b1);
        end
    endtask

    task automatic pulse_kick();
        kick = 1'b1;
        step(1'b0);
        kick = 1'b0;
    endtask

    task automatic set_sel(logic [1:0] s);
        wd_sel = s;
        step(1'b0);
    endtask

    initial begin
        @(negedge clk);
        repeat (3) step(1'b0);
        rst_n = 1'b1;
        step(1'b0);
        cur_req = "R1";
        check("R1 released after reset", rst_out_n, 1'b1);
        check("R10 high level means released", rst_out_n, 1'b1);

        cur_req = "R4";
        set_sel(2'b10);
        ticks(Q - 1); check("R4 high before short limit", rst_out_n, 1'b1);
        ticks(1);     check("R4 low at short limit", rst_out_n, 1'b0);
        check("R10 low level means pull down", rst_out_n, 1'b0);

        cur_req = "R8";
        pulse_kick();
        ticks(Q - 1); check("R8 still held, kick ignored", rst_out_n, 1'b0);
        ticks(1);     check("R8 released after hold", rst_out_n, 1'b1);
        ticks(Q - 1); check("R8 count restarted at release", rst_out_n, 1'b1);
        ticks(1);     check("R8 expiry after restart", rst_out_n, 1'b0);
        ticks(Q);

        cur_req = "R3";
        set_sel(2'b01);
        ticks(3 * Q - 1); check("R3 high before middle limit", rst_out_n, 1'b1);
        ticks(1);         check("R3 low at middle limit", rst_out_n, 1'b0);
        ticks(Q);

        cur_req = "R2";
        set_sel(2'b00);
        ticks(7 * Q - 1); check("R2 high before long limit", rst_out_n, 1'b1);
        ticks(1);         check("R2 low at long limit", rst_out_n, 1'b0);
        ticks(Q);

        cur_req = "R6";
        set_sel(2'b10);
        ticks(Q - 1);
        pulse_kick();
        ticks(Q - 1); check("R6 kick restarted count", rst_out_n, 1'b1);
        ticks(1);     check("R6 expiry after kick", rst_out_n, 1'b0);
        ticks(Q);

        cur_req = "R7";
        ticks(Q - 1);
        set_sel(2'b01);
        ticks(3 * Q - 1); check("R7 select change restarted count", rst_out_n, 1'b1);
        ticks(1);         check("R7 expiry at new limit", rst_out_n, 1'b0);
        ticks(Q);

        cur_req = "R5";
        set_sel(2'b11);
        ticks(10 * Q); check("R5 off never resets", rst_out_n, 1'b1);
        set_sel(2'b10);
        ticks(Q - 1); check("R5 re-enabled counts from zero", rst_out_n, 1'b1);
        ticks(1);     check("R5 re-enabled expiry", rst_out_n, 1'b0);
        ticks(Q);

        cur_req = "R11";
        set_sel(2'b01);
        repeat (60) step(1'b0);
        check("R11 no ticks no expiry", rst_out_n, 1'b1);
        ticks(3 * Q - 1); check("R11 idle cycles not counted", rst_out_n, 1'b1);
        ticks(1);         check("R11 expiry on ticks only", rst_out_n, 1'b0);
        ticks(Q);

        cur_req = "R9";
        set_sel(2'b11);
        lv_flag = 1'b1;
        step(1'b0);   check("R9 low right after flag", rst_out_n, 1'b0);
        ticks(2 * Q); check("R9 held while flag high", rst_out_n, 1'b0);
        lv_flag = 1'b0;
        ticks(Q - 1); check("R9 held during release delay", rst_out_n, 1'b0);
        ticks(1);     check("R9 released after delay", rst_out_n, 1'b1);
        step(1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, act=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule